// File: doc/BRIEF.md
# Paired Frame Sync Pulse Generator

This block turns a locked output clock into two low-rate pulse trains: a frame pulse and a multi-frame pulse. Both trains come from counting output-clock cycles, so their rate follows the clock reference the output clock is locked to. Their phase comes from a separate low-rate sync input that is paired with that reference. Any ordinary reference input can be routed to `sync_in`. The block does not use a narrow-bandwidth loop. It moves its counters directly onto a sync edge when that edge lands too far from where the counters expect it.

The sync input runs at one of four rates: 8 kHz, 4 kHz, 2 kHz or one pulse per second. The rate sets how many frames make up one sync period. An edge that falls within a programmable tolerance of a sync-period boundary is accepted without any change. An edge outside that tolerance restarts the frame. When edges stop arriving, the outputs keep running on the counters, and a loss flag rises after a configured number of empty periods. A separate mode drops both outputs to one pulse per second.

Top module: `fsync_pair_gen`

## Requirements
- R1: While `rst_n` is low, `frame_pulse`, `mframe_pulse` and `sync_lost` are 0. The first clock cycle after reset release carries both a frame pulse and a multi-frame pulse.
- R2: With no realignment, `frame_pulse` is high for exactly one cycle out of every `cfg_frame_len`+1 cycles. `cfg_frame_len` must be at least 1.
- R3: With `cfg_pps_out`=0, `mframe_pulse` is high on one frame pulse out of every `cfg_mf_len`+1 frame pulses. `mframe_pulse` is never high without `frame_pulse`.
- R4: `sync_in` passes through two synchronizing flops, and each rising edge becomes a one-cycle sync event. An event outside the tolerance window puts a frame pulse on the cycle after the event. That is the third rising clock edge after `sync_in` goes high.
- R5: An event is inside the window when either of two conditions holds. First, the counters are in frame 0 of the sync period and no more than `cfg_tol` cycles into it. Second, they are in the last frame of the sync period and no more than `cfg_tol` cycles before its end. An in-window event changes no output.
- R6: `cfg_sync_sel` encodes the sync rate and so the sync period in frames: 0 = 8 kHz (1 frame), 1 = 4 kHz (2 frames), 2 = 2 kHz (4 frames), 3 = 1 PPS (`cfg_pps_frames`+1 frames).
- R7: On a realignment, the multi-frame position restarts at 0 for rates 2 and 3, and advances by one frame for rates 0 and 1. The one-second position restarts at 0 for rate 3 only, and advances by one frame otherwise.
- R8: With `cfg_pps_out`=1, both outputs pulse only on the first cycle of a one-second interval of `cfg_pps_frames`+1 frames.
- R9: A miss counter (saturating at its maximum) counts sync-period ends that pass without realignment and clears on every sync event. `sync_lost` is high while that count exceeds `cfg_miss_lim`, and the pulse outputs keep running throughout.
- R10: With `cfg_tol`=0, only an event that lands exactly on the first cycle of a sync period is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Locked output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | Paired low-rate sync input (asynchronous) |
| cfg_frame_len | input | CNT_W | Output-clock cycles per frame, minus one |
| cfg_mf_len | input | MF_W | Frames per multi-frame, minus one |
| cfg_pps_frames | input | FRM_W | Frames per second, minus one |
| cfg_sync_sel | input | 2 | Sync input rate (0 = 8 kHz, 1 = 4 kHz, 2 = 2 kHz, 3 = 1 PPS) |
| cfg_pps_out | input | 1 | Both outputs at one pulse per second |
| cfg_tol | input | CNT_W | Tolerance window half-width in cycles |
| cfg_miss_lim | input | MISS_W | Empty sync periods tolerated before loss |
| frame_pulse | output | 1 | Frame sync pulse, one cycle wide |
| mframe_pulse | output | 1 | Multi-frame sync pulse, one cycle wide |
| sync_lost | output | 1 | Sync input considered missing |

## Verification
The assertions check four things on every cycle. A multi-frame pulse never appears without a frame pulse. A frame pulse is never two cycles long outside a realignment. A sync event is a single cycle and always clears the loss flag. The event also settles the next cycle's pulse correctly, both when it is outside the window and when it is inside. Three properties need whole scenarios instead, run by the bench for each sync rate and output mode. The first is the exact phase reached after a realignment. The second is where the window edges fall, found by sweeping the edge offset one cycle at a time. The third is how the multi-frame and one-second positions carry across a realignment, along with the timing of loss and recovery.

// File: rtl/fsp_pkg.sv
// Package: shared encodings for the paired frame sync generator.
// Assumes nothing beyond the two-bit rate select of the top level.
package fsp_pkg;
    typedef enum logic [1:0] {
        RATE_8K  = 2'd0,
        RATE_4K  = 2'd1,
        RATE_2K  = 2'd2,
        RATE_PPS = 2'd3
    } sync_rate_e;

    // A sync period that spans whole multi-frames restarts the multi-frame count
    function automatic logic rate_resets_mf(input logic [1:0] sel);
        return (sel == RATE_2K) || (sel == RATE_PPS);
    endfunction
endpackage

// File: rtl/fsp_sync_detect.sv
// Module: brings the asynchronous sync input into the clock domain and
// marks each rising edge with a one-cycle event.
// Assumes sync_in stays high or low for at least two clock cycles.
module fsp_sync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic sync_evt
);
    localparam int PIPE_W = SYNC_STAGES + 1;

    logic [PIPE_W-1:0] pipe_q;

    // Shift the input through the synchronizer and one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[PIPE_W-2:0], sync_in};
        end
    end

    // Rising edge seen at the synchronizer output
    assign sync_evt = pipe_q[PIPE_W-2] & ~pipe_q[PIPE_W-1];

    p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> !sync_evt)
        else $error("sync event lasted more than one cycle");
endmodule

// File: rtl/fsp_phase_cnt.sv
// Module: cycle, frame, multi-frame and one-second counters, tolerance
// window test and realignment. Decodes the two pulse outputs.
// Assumes cfg_frame_len >= 1 and that configuration changes only in reset.
module fsp_phase_cnt
    import fsp_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int FRM_W = 14,
    parameter int MF_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_evt,
    input  logic [CNT_W-1:0] cfg_frame_len,
    input  logic [MF_W-1:0]  cfg_mf_len,
    input  logic [FRM_W-1:0] cfg_pps_frames,
    input  logic [1:0]       cfg_sync_sel,
    input  logic             cfg_pps_out,
    input  logic [CNT_W-1:0] cfg_tol,
    output logic             frame_pulse,
    output logic             mframe_pulse,
    output logic             period_end
);
    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] cyc_q;
    logic [FRM_W-1:0] spf_q;
    logic [FRM_W-1:0] sec_q;
    logic [MF_W-1:0]  mfi_q;
    logic [FRM_W-1:0] sp_last;
    logic [SUM_W-1:0] early_sum;
    logic             late_ok;
    logic             early_ok;
    logic             in_win;
    logic             realign;
    logic             frame_end;
    logic [MF_W-1:0]  mfi_step;
    logic [FRM_W-1:0] sec_step;

    // Last frame index of the sync period for the chosen rate
    always_comb begin
        unique case (sync_rate_e'(cfg_sync_sel))
            RATE_8K:  sp_last = FRM_W'(0);
            RATE_4K:  sp_last = FRM_W'(1);
            RATE_2K:  sp_last = FRM_W'(3);
            default:  sp_last = cfg_pps_frames;
        endcase
    end

    // Window test: just after a period start, or just before a period end
    always_comb begin
        early_sum = {1'b0, cyc_q} + {1'b0, cfg_tol};
        late_ok   = (spf_q == '0) && (cyc_q <= cfg_tol);
        early_ok  = (spf_q == sp_last) && (early_sum > {1'b0, cfg_frame_len});
        in_win    = late_ok || early_ok;
        realign   = sync_evt && !in_win;
        frame_end = (cyc_q >= cfg_frame_len);
    end

    // Positions one frame further on, wrapping at their limits
    always_comb begin
        mfi_step = (mfi_q >= cfg_mf_len) ? '0 : mfi_q + 1'b1;
        sec_step = (sec_q >= cfg_pps_frames) ? '0 : sec_q + 1'b1;
    end

    // Advance the counters, or restart the frame on an out-of-window edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= cfg_frame_len;
            spf_q <= sp_last;
            mfi_q <= cfg_mf_len;
            sec_q <= cfg_pps_frames;
        end else if (realign) begin
            cyc_q <= '0;
            spf_q <= '0;
            mfi_q <= rate_resets_mf(cfg_sync_sel) ? '0 : mfi_step;
            sec_q <= (cfg_sync_sel == RATE_PPS) ? '0 : sec_step;
        end else if (frame_end) begin
            cyc_q <= '0;
            spf_q <= (spf_q >= sp_last) ? '0 : spf_q + 1'b1;
            mfi_q <= mfi_step;
            sec_q <= sec_step;
        end else begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // Pulse decode from the counter state
    always_comb begin
        frame_pulse  = (cyc_q == '0) && (!cfg_pps_out || (sec_q == '0));
        mframe_pulse = (cyc_q == '0) && (cfg_pps_out ? (sec_q == '0) : (mfi_q == '0));
        period_end   = frame_end && (spf_q >= sp_last) && !realign;
    end

    p_realign_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && !in_win && !cfg_pps_out) |=> frame_pulse)
        else $error("realignment did not start a frame");

    p_inwin_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && in_win && !frame_end) |=> !frame_pulse)
        else $error("accepted edge moved the frame");
endmodule

// File: rtl/fsp_loss_mon.sv
// Module: counts sync-period ends that pass without a sync edge and raises
// the loss flag once the count exceeds the configured limit.
// Assumes period_end is never high in a cycle with a realignment.
module fsp_loss_mon #(
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_evt,
    input  logic              period_end,
    input  logic [MISS_W-1:0] cfg_miss_lim,
    output logic              sync_lost
);
    localparam logic [MISS_W-1:0] MISS_MAX = {MISS_W{1'b1}};

    logic [MISS_W-1:0] miss_q;

    // Clear on any edge, else count period ends up to saturation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            miss_q <= '0;
        end else if (sync_evt) begin
            miss_q <= '0;
        end else if (period_end && (miss_q != MISS_MAX)) begin
            miss_q <= miss_q + 1'b1;
        end
    end

    // Loss flag from the registered count
    assign sync_lost = (miss_q > cfg_miss_lim);

    p_lost_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sync_evt |=> !sync_lost)
        else $error("loss flag survived a sync edge");
endmodule

// File: rtl/fsync_pair_gen.sv
// Module: top of the paired frame sync generator. Connects the edge
// detector, the phase counters and the loss monitor.
// Assumes clk is the locked output clock and configuration is static
// outside reset.
module fsync_pair_gen #(
    parameter int CNT_W  = 16,
    parameter int FRM_W  = 14,
    parameter int MF_W   = 4,
    parameter int MISS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync_in,
    input  logic [CNT_W-1:0]  cfg_frame_len,
    input  logic [MF_W-1:0]   cfg_mf_len,
    input  logic [FRM_W-1:0]  cfg_pps_frames,
    input  logic [1:0]        cfg_sync_sel,
    input  logic              cfg_pps_out,
    input  logic [CNT_W-1:0]  cfg_tol,
    input  logic [MISS_W-1:0] cfg_miss_lim,
    output logic              frame_pulse,
    output logic              mframe_pulse,
    output logic              sync_lost
);
    logic sync_evt;
    logic period_end;

    fsp_sync_detect #(.SYNC_STAGES(2)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (sync_in),
        .sync_evt (sync_evt)
    );

    fsp_phase_cnt #(.CNT_W(CNT_W), .FRM_W(FRM_W), .MF_W(MF_W)) u_phase (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_evt       (sync_evt),
        .cfg_frame_len  (cfg_frame_len),
        .cfg_mf_len     (cfg_mf_len),
        .cfg_pps_frames (cfg_pps_frames),
        .cfg_sync_sel   (cfg_sync_sel),
        .cfg_pps_out    (cfg_pps_out),
        .cfg_tol        (cfg_tol),
        .frame_pulse    (frame_pulse),
        .mframe_pulse   (mframe_pulse),
        .period_end     (period_end)
    );

    fsp_loss_mon #(.MISS_W(MISS_W)) u_loss (
        .clk          (clk),
        .rst_n        (rst_n),
        .sync_evt     (sync_evt),
        .period_end   (period_end),
        .cfg_miss_lim (cfg_miss_lim),
        .sync_lost    (sync_lost)
    );

    p_mf_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mframe_pulse |-> frame_pulse)
        else $error("multi-frame pulse without frame pulse");

    p_frame_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && !sync_evt && (cfg_frame_len != '0)) |=> !frame_pulse)
        else $error("frame pulse wider than one cycle");
endmodule

// File: tb/tb_fsync_pair_gen.sv
// Bench: sweeps every sync rate with both output modes, moves the sync edge
// through every offset around the window, then withdraws and restores it.
// The expected outputs come from an arithmetic model of the requirements.
module tb_fsync_pair_gen;
    localparam int CNT_W  = 16;
    localparam int FRM_W  = 14;
    localparam int MF_W   = 4;
    localparam int MISS_W = 4;
    localparam int MISS_MAX = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic [CNT_W-1:0]  cfg_frame_len = 16'd9;
    logic [MF_W-1:0]   cfg_mf_len = 4'd3;
    logic [FRM_W-1:0]  cfg_pps_frames = 14'd7;
    logic [1:0]        cfg_sync_sel = 2'd0;
    logic              cfg_pps_out = 1'b0;
    logic [CNT_W-1:0]  cfg_tol = 16'd2;
    logic [MISS_W-1:0] cfg_miss_lim = 4'd2;
    logic frame_pulse, mframe_pulse, sync_lost;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    // model state
    int m_cyc, m_spf, m_mfi, m_sec, m_miss;
    bit b1, b2, b3;

    always #10 clk = ~clk;

    fsync_pair_gen #(.CNT_W(CNT_W), .FRM_W(FRM_W), .MF_W(MF_W), .MISS_W(MISS_W)) dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in),
        .cfg_frame_len(cfg_frame_len), .cfg_mf_len(cfg_mf_len),
        .cfg_pps_frames(cfg_pps_frames), .cfg_sync_sel(cfg_sync_sel),
        .cfg_pps_out(cfg_pps_out), .cfg_tol(cfg_tol), .cfg_miss_lim(cfg_miss_lim),
        .frame_pulse(frame_pulse), .mframe_pulse(mframe_pulse), .sync_lost(sync_lost)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
        end
    endtask

    // R6: sync period length in frames, minus one
    function automatic int sp_last();
        case (cfg_sync_sel)
            2'd0: return 0;
            2'd1: return 1;
            2'd2: return 3;
            default: return int'(cfg_pps_frames);
        endcase
    endfunction

    // Apply one rising clock edge to the model
    task automatic model_edge();
        bit evt, inwin, re, fend, pend;
        int spl, fl, mfl, psl;
        spl = sp_last();
        fl = int'(cfg_frame_len);
        mfl = int'(cfg_mf_len);
        psl = int'(cfg_pps_frames);
        if (!rst_n) begin
            m_cyc = fl; m_spf = spl; m_mfi = mfl; m_sec = psl; m_miss = 0;
            b1 = 0; b2 = 0; b3 = 0;
        end else begin
            evt = b2 && !b3;                                          // R4
            inwin = (m_spf == 0 && m_cyc <= int'(cfg_tol)) ||
                    (m_spf == spl && (fl - m_cyc + 1) <= int'(cfg_tol)); // R5 R10
            re = evt && !inwin;
            fend = (m_cyc >= fl);
            pend = fend && (m_spf >= spl) && !re;
            if (evt) m_miss = 0;                                       // R9
            else if (pend && m_miss < MISS_MAX) m_miss++;
            if (re) begin
                m_cyc = 0; m_spf = 0;
                m_mfi = (cfg_sync_sel >= 2) ? 0 : ((m_mfi >= mfl) ? 0 : m_mfi + 1); // R7
                m_sec = (cfg_sync_sel == 3) ? 0 : ((m_sec >= psl) ? 0 : m_sec + 1);
            end else if (fend) begin
                m_cyc = 0;
                m_spf = (m_spf >= spl) ? 0 : m_spf + 1;
                m_mfi = (m_mfi >= mfl) ? 0 : m_mfi + 1;
                m_sec = (m_sec >= psl) ? 0 : m_sec + 1;
            end else begin
                m_cyc++;
            end
            b3 = b2; b2 = b1; b1 = sync_in;
        end
    endtask

    // One cycle: drive, clock the model, compare away from the edge
    task automatic tick(input logic s);
        logic ef, em;
        sync_in = s;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ef = (rst_n && m_cyc == 0) && (!cfg_pps_out || m_sec == 0);              // R2 R8
        em = (rst_n && m_cyc == 0) && (cfg_pps_out ? (m_sec == 0) : (m_mfi == 0)); // R3 R8
        chk({cur_req, " frame_pulse"}, frame_pulse, ef);
        chk({cur_req, " mframe_pulse"}, mframe_pulse, em);
        chk({cur_req, " sync_lost"}, sync_lost, rst_n && (m_miss > int'(cfg_miss_lim)));
        if (mframe_pulse) chk("R3 mframe implies frame", frame_pulse, 1'b1);
    endtask

    task automatic send_sync(input int gap);
        tick(1'b1);
        tick(1'b1);
        for (int i = 2; i < gap; i++) tick(1'b0);
    endtask

    task automatic run_combo(input logic [1:0] sel, input logic pps, input int tol);
        int per;
        cfg_sync_sel = sel;
        cfg_pps_out = pps;
        cfg_tol = CNT_W'(tol);
        per = (sp_last() + 1) * (int'(cfg_frame_len) + 1);
        rst_n = 1'b0;
        cur_req = "R1";
        tick(1'b0); tick(1'b0); tick(1'b0);
        chk("R1 reset frame_pulse", frame_pulse, 1'b0);
        chk("R1 reset mframe_pulse", mframe_pulse, 1'b0);
        chk("R1 reset sync_lost", sync_lost, 1'b0);
        rst_n = 1'b1;
        tick(1'b0);
        chk("R1 first frame pulse", frame_pulse, 1'b1);
        chk("R1 first mframe pulse", mframe_pulse, 1'b1);
        cur_req = pps ? "R2 R8" : "R2 R3";
        for (int i = 0; i < 2 * per + 5; i++) tick(1'b0);
        // R4 R5 R6 R7: edge offset swept one cycle at a time across the window
        cur_req = pps ? "R4 R5 R6 R7 R8" : "R4 R5 R6 R7";
        if (tol == 0) cur_req = "R10";
        for (int k = 0; k < 12; k++) send_sync(per - 6 + k);
        for (int k = 0; k < 6; k++) send_sync(per);
        // R9: withdraw sync; outputs keep running, then the flag rises
        cur_req = "R9";
        for (int i = 0; i < (int'(cfg_miss_lim) + 3) * per; i++) tick(1'b0);
        chk("R9 sync_lost after silence", sync_lost, 1'b1);
        send_sync(4);
        chk("R9 sync_lost cleared by edge", sync_lost, 1'b0);
        for (int i = 0; i < per; i++) tick(1'b0);
    endtask

    initial begin
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            run_combo(2'(s), 1'b0, 2);
            run_combo(2'(s), 1'b1, 2);
        end
        run_combo(2'd0, 1'b0, 0);
        run_combo(2'd2, 1'b0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule